// File: doc/BRIEF.md
# Shared-Pin GPIO Port with PWM Override

This block is a six-pin general-purpose I/O port whose pins are shared with a six-channel PWM generator. Software reaches it over a small synchronous register bus. The bus has an address, a write strobe, write data and registered read data. Through this bus it can reach three registers: a latched data register, a direction register and a read-only view of the pin levels. For every pin the block drives an output value and an output enable toward a tri-state pad, and it reads the pad level back.

Pin ownership is resolved per pin by a fixed priority. When the PWM channel for a pin is enabled, that pin becomes an output that carries the channel's waveform. In that case the direction and data bits for the pin have no effect on the pad. The data register still keeps and accepts values while the PWM owns the pin, so the port can take the pin back without being reprogrammed. Pad levels pass through a synchronizer before any register read sees them. That synchronizer has no reset, so the pin view stays live across reset.

Top module: `pport_top`

## Requirements
- R1: While reset is held and after it is released, the data and direction registers are zero, read data is zero during reset, and with every PWM enable low every pad output enable is low.
- R2: A write to offset 2 sets the direction register from write data bits 5:0. A read of offset 2 returns it, with bits 7:6 as 0.
- R3: A read of offset 0 returns, for each pin whose direction bit is 1, the latched data bit. Bits 7:6 read as 0.
- R4: A read of offset 0 returns, for each pin whose direction bit is 0, the pad level as seen through the synchronizer. A pad change made before clock edge e is first visible in read data sampled after edge e+2 (the third edge).
- R5: A read of offset 1 returns the synchronized pad level of all six pins, whatever their direction, including the levels the port itself drives.
- R6: A write to offset 1 changes neither the data register, nor the direction register, nor any pad output.
- R7: A read of any offset other than 0, 1 and 2 returns 0. A write to such an offset changes no register and no pad output.
- R8: With a pin's PWM enable low, its output enable equals its direction bit and its output value equals its data bit. Both take on new register values right after the write edge.
- R9: With a pin's PWM enable high, its output enable is 1 and its output value follows the PWM waveform input in the same cycle, whatever the direction and data bits hold.
- R10: Writes to the data register take effect while PWM owns a pin. When the enable drops, the pin shows the newly written data bit.
- R11: The synchronizer is not cleared by reset. A read of offset 1 issued in the first cycle after reset release returns the pad levels that were held during reset.
- R12: Read data is registered. It reflects the address presented before an edge, and a read that coincides with a write to the same register returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_en | input | 6 | Per-pin PWM channel enable |
| pwm_wave | input | 6 | Per-pin PWM waveform |
| pad_in | input | 6 | Pad levels seen at the pins |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables (1 drives) |

## Verification
The pad outputs are combinational from register state and the PWM inputs. They are therefore compared in the same cycle as a PWM change, and in the cycle that follows a write edge. Read data is due one edge after the address is presented. A pad level reaches read data only on the third edge, because two synchronizer stages and the read register sit on the way. The bench's behavioural model applies exactly these delays, and all of its comparisons are made at the falling edge, after each rising edge has settled.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int unsigned OFF_DATA = 0;
    localparam int unsigned OFF_PINS = 1;
    localparam int unsigned OFF_DIR  = 2;

    typedef enum logic [1:0] {
        SEL_DATA,
        SEL_PINS,
        SEL_DIR,
        SEL_NONE
    } pport_sel_e;

    function automatic pport_sel_e pport_decode(input logic [31:0] offs);
        pport_sel_e sel;
        case (offs)
            32'(OFF_DATA): sel = SEL_DATA;
            32'(OFF_PINS): sel = SEL_PINS;
            32'(OFF_DIR):  sel = SEL_DIR;
            default:       sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    // Stage flops carry no reset: they mirror the pads, not stored state.
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = async_in;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk) begin
            stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int WIDTH  = 6,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t      st_d, st_q;
    pport_sel_e wsel;

    always_comb begin
        wsel = pport_decode(32'(addr));
        st_d = st_q;
        if (we) begin
            case (wsel)
                SEL_DATA: st_d.data = wdata[WIDTH-1:0];
                SEL_DIR:  st_d.dir  = wdata[WIDTH-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q = st_q.data;
    assign dir_q  = st_q.dir;

    // R2
    dir_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFF_DIR)) |=> (dir_q == $past(wdata[WIDTH-1:0])));

    // R2
    dir_upper_bits_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFF_DIR) && (wdata[DATA_W-1:WIDTH] != '0))
        |=> (dir_q == $past(wdata[WIDTH-1:0])));

    // R6
    pin_view_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFF_PINS)) |=> ($stable(data_q) && $stable(dir_q)));

    // R10
    data_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(OFF_DATA)) |=> (data_q == $past(wdata[WIDTH-1:0])));

endmodule

// File: rtl/pport_pinmux.sv
module pport_pinmux #(
    parameter int WIDTH = 6
) (
    input  logic [WIDTH-1:0] pwm_en,
    input  logic [WIDTH-1:0] pwm_wave,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    // Per-pin owner: PWM first, port logic second.
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            if (pwm_en[i]) begin
                pad_oe[i]  = 1'b1;
                pad_out[i] = pwm_wave[i];
            end else begin
                pad_oe[i]  = dir[i];
                pad_out[i] = data[i];
            end
        end
    end

endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
#(
    parameter int PINS        = 6,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pwm_en,
    input  logic [PINS-1:0]   pwm_wave,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);

    logic [PINS-1:0] data_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] pins_sync;

    pport_regs #(
        .WIDTH  (PINS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    pport_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    pport_pinmux #(
        .WIDTH (PINS)
    ) u_mux (
        .pwm_en   (pwm_en),
        .pwm_wave (pwm_wave),
        .data     (data_q),
        .dir      (dir_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t        rd_d, rd_q;
    pport_sel_e rsel;

    always_comb begin
        rsel     = pport_decode(32'(bus_addr));
        rd_d     = '0;
        case (rsel)
            SEL_DATA: rd_d.rdata[PINS-1:0] = (dir_q & data_q) | (~dir_q & pins_sync);
            SEL_PINS: rd_d.rdata[PINS-1:0] = pins_sync;
            SEL_DIR:  rd_d.rdata[PINS-1:0] = dir_q;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    // R3
    out_bits_read_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_DATA))
        |=> (((bus_rdata[PINS-1:0] ^ $past(data_q)) & $past(dir_q)) == '0));

    // R7
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > ADDR_W'(OFF_DIR)) |=> (bus_rdata == '0));

    // R9
    pwm_owns_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pwm_en) == pwm_en));

    // R9
    pwm_owns_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ pwm_wave) & pwm_en) == '0));

endmodule

// File: tb/pport_top_test.sv
`timescale 1ns/1ps
module pport_top_test;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [5:0] pwm_en;
    logic [5:0] pwm_wave;
    logic [5:0] ext;
    logic [5:0] pad_in;
    logic [5:0] pad_out;
    logic [5:0] pad_oe;

    int    checks   = 0;
    int    failures = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    logic [5:0] m_data = '0, m_dir = '0, m_s1 = '0, m_s2 = '0;
    logic [7:0] m_rd = '0;

    always #HALF clk = ~clk;

    // Pad model: a driven pin shows the port's value, else the outside level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    pport_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_en    (pwm_en),
        .pwm_wave  (pwm_wave),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] m_oe();
        return pwm_en | m_dir;
    endfunction

    function automatic logic [5:0] m_out();
        return (pwm_en & pwm_wave) | (~pwm_en & m_data);
    endfunction

    task automatic tick();
        logic [5:0] pins;
        @(posedge clk);
        pins = (m_oe() & m_out()) | (~m_oe() & ext);
        if (!rst_n) m_rd = '0;
        else begin
            case (bus_addr)
                4'd0:    m_rd = {2'b00, (m_dir & m_data) | (~m_dir & m_s2)};
                4'd1:    m_rd = {2'b00, m_s2};
                4'd2:    m_rd = {2'b00, m_dir};
                default: m_rd = '0;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = pins;
        if (!rst_n) begin
            m_data = '0;
            m_dir  = '0;
        end else if (bus_we) begin
            if (bus_addr == 4'd0) m_data = bus_wdata[5:0];
            if (bus_addr == 4'd2) m_dir  = bus_wdata[5:0];
        end
        @(negedge clk);
        chk(cur_req, "pad_oe",    {2'b00, pad_oe},  {2'b00, m_oe()});
        chk(cur_req, "pad_out",   {2'b00, pad_out}, {2'b00, m_out()});
        chk(cur_req, "bus_rdata", bus_rdata, m_rd);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        tick();
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input int n);
        bus_addr = a;
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        #(HALF * 2 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = 4'd1; bus_we = 1'b0; bus_wdata = '0;
        pwm_en = '0; pwm_wave = '0; ext = 6'h2A;

        cur_req = "R1";
        for (int k = 0; k < 4; k++) tick();
        chk("R1", "pad_oe reset", {2'b00, pad_oe}, 8'h00);
        chk("R1", "rdata reset", bus_rdata, 8'h00);

        cur_req = "R11";
        rst_n = 1'b1;
        tick();
        chk("R11", "pin view after release", bus_rdata, 8'h2A);

        cur_req = "R1";
        rd(4'd2, 1);
        chk("R1", "dir after reset", bus_rdata, 8'h00);
        rd(4'd0, 1);

        cur_req = "R2";
        wr(4'd2, 8'hFF);
        rd(4'd2, 2);
        chk("R2", "dir readback", bus_rdata, 8'h3F);
        wr(4'd2, 8'hC5);
        rd(4'd2, 1);
        chk("R2", "dir readback 2", bus_rdata, 8'h05);

        cur_req = "R8";
        wr(4'd2, 8'h0F);
        wr(4'd0, 8'h35);
        chk("R8", "pad_oe from dir", {2'b00, pad_oe}, 8'h0F);
        chk("R8", "pad_out from data", {2'b00, pad_out}, 8'h35);

        cur_req = "R3";
        rd(4'd0, 4);
        chk("R3", "driven bits latched", bus_rdata & 8'h0F, 8'h05);

        cur_req = "R4";
        ext = 6'h10;
        rd(4'd0, 1);
        rd(4'd0, 1);
        ext = 6'h20;
        rd(4'd0, 4);
        ext = 6'h30;
        rd(4'd0, 4);
        chk("R4", "input bits follow pins", bus_rdata & 8'hF0, 8'h30);

        cur_req = "R5";
        rd(4'd1, 4);
        chk("R5", "pin view shows driven", bus_rdata, 8'h35);

        cur_req = "R12";
        bus_addr = 4'd2; bus_wdata = 8'h3C; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
        chk("R12", "read during write old", bus_rdata, 8'h0F);
        rd(4'd2, 1);
        chk("R12", "read after write new", bus_rdata, 8'h3C);

        cur_req = "R6";
        wr(4'd1, 8'hFF);
        rd(4'd2, 1);
        chk("R6", "dir untouched", bus_rdata, 8'h3C);
        rd(4'd0, 1);
        rd(4'd1, 3);

        cur_req = "R7";
        wr(4'd3, 8'hFF);
        wr(4'd15, 8'h00);
        rd(4'd3, 1);
        chk("R7", "offset 3 reads zero", bus_rdata, 8'h00);
        rd(4'd7, 1);
        rd(4'd15, 1);
        rd(4'd2, 1);
        chk("R7", "dir unchanged", bus_rdata, 8'h3C);

        cur_req = "R9";
        wr(4'd2, 8'h00);
        pwm_en = 6'h21;
        for (int k = 0; k < 6; k++) begin
            pwm_wave = (k % 2 == 0) ? 6'h3F : 6'h00;
            rd(4'd1, 1);
        end
        pwm_en = 6'h3F; pwm_wave = 6'h15;
        rd(4'd0, 1);
        chk("R9", "pwm value", {2'b00, pad_out}, 8'h15);
        chk("R9", "pwm enable", {2'b00, pad_oe}, 8'h3F);

        cur_req = "R10";
        wr(4'd2, 8'h3F);
        wr(4'd0, 8'h0A);
        rd(4'd0, 2);
        pwm_en = 6'h00;
        rd(4'd0, 2);
        chk("R10", "pins back to data", {2'b00, pad_out}, 8'h0A);

        cur_req = "R4";
        for (int k = 0; k < 400; k++) begin
            ext      = 6'($urandom);
            pwm_en   = ((k % 7) == 0) ? 6'($urandom) : 6'h00;
            pwm_wave = 6'($urandom);
            bus_addr = 4'($urandom % 5);
            bus_we   = ($urandom % 4) == 0;
            bus_wdata = 8'($urandom);
            tick();
        end
        bus_we = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule